// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches the processor's address streams and raises a one-cycle match pulse when an address falls inside a programmed window. It holds up to two comparators. Each comparator has a 32-bit compare value, a 4-bit span code and a 4-bit function code. The span code k makes the comparator ignore the k lowest address bits, so one comparator covers an aligned window of 2^k bytes. The function code selects what the comparator looks at: the executing instruction address, data reads, data writes, or both kinds of data access.

The block also provides a sample register for simple statistical profiling. Reading it returns the current instruction address while the core runs with the unit enabled. A debugger reads and writes every register over a simple register bus: a write strobe, a byte offset and write data, with read data returned combinationally for the offset on the bus.

The unit-enable input comes from the monitor control logic. While it is low, register writes are dropped and no match pulse is produced.

Top module: `wpt_unit`

## Requirements
- R1: Reading offset 0x000 returns the comparator count NCMP in bits 31:28 and zero in all other bits.
- R2: Reading offset 0x01C returns `instr_addr` when `unit_en`=1 and `halted`=0, and returns 0xFFFFFFFF otherwise.
- R3: The span code k is stored in bits 3:0 at offset 0x24+0x10*n and reads back zero-extended. An address matches comparator n when bits 31:k of the address equal bits 31:k of its compare value. k=0 compares all 32 bits and k=15 ignores bits 14:0.
- R4: The function code is held in bits 3:0 at offset 0x28+0x10*n. Code 0000 disables the comparator. 0100 matches `instr_addr` on `instr_valid`. 0101 matches `data_addr` when `data_valid`=1 and `data_write`=0. 0110 matches `data_addr` when `data_valid`=1 and `data_write`=1. 0111 matches `data_addr` on any `data_valid`.
- R5: Every function code not listed in R4 behaves as disabled, but it still reads back as written.
- R6: The compare value is a full 32-bit register at offset 0x20+0x10*n. Unmapped offsets read as zero.
- R7: A register write made while `unit_en`=0 leaves every register unchanged.
- R8: While `unit_en`=0, `wp_match` stays low, whatever the comparators would match.
- R9: Reset (`rst`=1, synchronous) clears every compare value, span code and function code to zero, and clears `wp_match`.
- R10: `wp_match` is high in the cycle after a clock edge at which at least one comparator matches. It is the OR of all comparators, and it lasts one cycle per matching event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_en | input | 1 | Unit enable from monitor control |
| halted | input | 1 | Core halted flag |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | RAW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| instr_valid | input | 1 | Instruction address valid |
| instr_addr | input | 32 | Current instruction address |
| data_valid | input | 1 | Data access strobe |
| data_write | input | 1 | Data access is a write (1) or a read (0) |
| data_addr | input | 32 | Data access address |
| wp_match | output | 1 | Watchpoint match pulse |

## Verification
The assertions assume that all inputs hold known values from the first clock edge on, and that `data_write` is meaningful only while `data_valid` is high. They also assume that a match can only follow a cycle in which a valid strobe was present. The stimulus changes every input at the falling clock edge only. It raises each strobe for exactly one cycle, and it programs compare values aligned to the largest span, so window membership depends only on the span code.

// File: rtl/wpt_pkg.sv
`timescale 1ns/1ps
package wpt_pkg;

    localparam int ADDR_W = 32;
    localparam int CODE_W = 4;

    // Function codes
    localparam logic [CODE_W-1:0] FN_OFF = 4'b0000;
    localparam logic [CODE_W-1:0] FN_PC  = 4'b0100;
    localparam logic [CODE_W-1:0] FN_RD  = 4'b0101;
    localparam logic [CODE_W-1:0] FN_WR  = 4'b0110;
    localparam logic [CODE_W-1:0] FN_RW  = 4'b0111;

    // Register map (byte offsets)
    localparam int OFS_CTRL     = 'h000;
    localparam int OFS_SAMPLE   = 'h01C;
    localparam int OFS_CMP_BASE = 'h020;
    localparam int CMP_STRIDE   = 'h010;
    localparam int SUB_VALUE    = 'h0;
    localparam int SUB_SPAN     = 'h4;
    localparam int SUB_FN       = 'h8;

    typedef struct packed {
        logic [ADDR_W-1:0] value;
        logic [CODE_W-1:0] span;
        logic [CODE_W-1:0] fn;
    } cmp_cfg_t;

    localparam int CFG_W = $bits(cmp_cfg_t);

    typedef struct packed {
        logic              iv;
        logic [ADDR_W-1:0] ia;
        logic              dv;
        logic              dw;
        logic [ADDR_W-1:0] da;
    } probe_t;

    function automatic logic [ADDR_W-1:0] span_mask(input logic [CODE_W-1:0] k);
        return {ADDR_W{1'b1}} << k;
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input cmp_cfg_t c);
        logic [ADDR_W-1:0] m;
        m = span_mask(c.span);
        return ((a ^ c.value) & m) == '0;
    endfunction

    function automatic logic fn_fires(input cmp_cfg_t c, input probe_t p);
        case (c.fn)
            FN_PC:   return p.iv && in_window(p.ia, c);
            FN_RD:   return p.dv && !p.dw && in_window(p.da, c);
            FN_WR:   return p.dv && p.dw && in_window(p.da, c);
            FN_RW:   return p.dv && in_window(p.da, c);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wpt_cmp.sv
`timescale 1ns/1ps
module wpt_cmp
    import wpt_pkg::*;
(
    input  cmp_cfg_t cfg,
    input  probe_t   probe,
    output logic     hit
);
    always_comb hit = fn_fires(cfg, probe);
endmodule

// File: rtl/wpt_regs.sv
`timescale 1ns/1ps
module wpt_regs
    import wpt_pkg::*;
#(
    parameter int NCMP  = 2,
    parameter int RAW   = 12,
    parameter int NSLOT = (NCMP > 0) ? NCMP : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unit_en,
    input  logic              bus_wen,
    input  logic [RAW-1:0]    bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [ADDR_W-1:0] sample,
    output logic [31:0]       bus_rdata,
    output cmp_cfg_t          cfg [NSLOT]
);
    localparam logic [RAW-1:0] A_CTRL   = RAW'(OFS_CTRL);
    localparam logic [RAW-1:0] A_SAMPLE = RAW'(OFS_SAMPLE);

    logic wr_ok;
    assign wr_ok = bus_wen && unit_en;

    for (genvar n = 0; n < NSLOT; n++) begin : g_slot
        localparam logic [RAW-1:0] A_VAL  = RAW'(OFS_CMP_BASE + CMP_STRIDE*n + SUB_VALUE);
        localparam logic [RAW-1:0] A_SPAN = RAW'(OFS_CMP_BASE + CMP_STRIDE*n + SUB_SPAN);
        localparam logic [RAW-1:0] A_FN   = RAW'(OFS_CMP_BASE + CMP_STRIDE*n + SUB_FN);
        if (n < NCMP) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg[n] <= '0;
                end else if (wr_ok) begin
                    if (bus_addr == A_VAL)  cfg[n].value <= bus_wdata;
                    if (bus_addr == A_SPAN) cfg[n].span  <= bus_wdata[CODE_W-1:0];
                    if (bus_addr == A_FN)   cfg[n].fn    <= bus_wdata[CODE_W-1:0];
                end
            end
        end else begin : g_absent
            assign cfg[n] = '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)   bus_rdata[31:28] = 4'(NCMP);
        if (bus_addr == A_SAMPLE) bus_rdata = sample;
        for (int n = 0; n < NCMP; n++) begin
            if (bus_addr == RAW'(OFS_CMP_BASE + CMP_STRIDE*n + SUB_VALUE))
                bus_rdata = cfg[n].value;
            if (bus_addr == RAW'(OFS_CMP_BASE + CMP_STRIDE*n + SUB_SPAN))
                bus_rdata = {28'd0, cfg[n].span};
            if (bus_addr == RAW'(OFS_CMP_BASE + CMP_STRIDE*n + SUB_FN))
                bus_rdata = {28'd0, cfg[n].fn};
        end
    end
endmodule

// File: rtl/wpt_unit.sv
`timescale 1ns/1ps
module wpt_unit
    import wpt_pkg::*;
#(
    parameter int NCMP = 2,
    parameter int RAW  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unit_en,
    input  logic              halted,
    input  logic              bus_wen,
    input  logic [RAW-1:0]    bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              instr_valid,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic              data_valid,
    input  logic              data_write,
    input  logic [ADDR_W-1:0] data_addr,
    output logic              wp_match
);
    localparam int NSLOT = (NCMP > 0) ? NCMP : 1;

    cmp_cfg_t          cfg [NSLOT];
    logic [NSLOT-1:0]  hits;
    logic [ADDR_W-1:0] sample;
    probe_t            probe;
    logic [NSLOT*CFG_W-1:0] cfg_flat;

    assign sample = (unit_en && !halted) ? instr_addr : {ADDR_W{1'b1}};
    assign probe  = '{iv: instr_valid, ia: instr_addr,
                      dv: data_valid, dw: data_write, da: data_addr};

    wpt_regs #(.NCMP(NCMP), .RAW(RAW), .NSLOT(NSLOT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .unit_en   (unit_en),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sample    (sample),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    for (genvar n = 0; n < NSLOT; n++) begin : g_cmp
        wpt_cmp u_cmp (.cfg(cfg[n]), .probe(probe), .hit(hits[n]));
        assign cfg_flat[n*CFG_W +: CFG_W] = cfg[n];
    end

    always_ff @(posedge clk) begin
        if (rst) wp_match <= 1'b0;
        else     wp_match <= unit_en && (|hits);
    end
endmodule

// File: rtl/wpt_unit_chk.sv
`timescale 1ns/1ps
module wpt_unit_chk #(
    parameter int NCMP   = 2,
    parameter int RAW    = 12,
    parameter int FLAT_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              unit_en,
    input logic              halted,
    input logic [RAW-1:0]    bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              instr_valid,
    input logic              data_valid,
    input logic              wp_match,
    input logic [FLAT_W-1:0] cfg_flat
);
    assert_ctrl_word_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == RAW'(0)) |-> (bus_rdata == {4'(NCMP), 28'd0}));

    assert_sample_blank_R2: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr == RAW'('h1C)) && (halted || !unit_en)) |-> (bus_rdata == 32'hFFFF_FFFF));

    assert_locked_cfg_R7: assert property (@(posedge clk) disable iff (rst)
        !unit_en |=> $stable(cfg_flat));

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !unit_en |=> !wp_match);

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!wp_match && cfg_flat == '0));

    assert_needs_event_R10: assert property (@(posedge clk) disable iff (rst)
        (!instr_valid && !data_valid) |=> !wp_match);
endmodule

bind wpt_unit wpt_unit_chk #(.NCMP(NCMP), .RAW(RAW), .FLAT_W(NSLOT*wpt_pkg::CFG_W)) u_chk (
    .clk(clk), .rst(rst), .unit_en(unit_en), .halted(halted),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .instr_valid(instr_valid), .data_valid(data_valid),
    .wp_match(wp_match), .cfg_flat(cfg_flat)
);

// File: tb/sim_wpt_unit.sv
`timescale 1ns/1ps
module sim_wpt_unit;
    localparam int RAW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic unit_en = 1'b0, halted = 1'b0, bus_wen = 1'b0;
    logic [RAW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic instr_valid = 1'b0, data_valid = 1'b0, data_write = 1'b0;
    logic [31:0] instr_addr = '0, data_addr = '0;
    logic wp_match;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wpt_unit #(.NCMP(2), .RAW(RAW)) u0 (
        .clk(clk), .rst(rst), .unit_en(unit_en), .halted(halted),
        .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .instr_valid(instr_valid), .instr_addr(instr_addr),
        .data_valid(data_valid), .data_write(data_write), .data_addr(data_addr),
        .wp_match(wp_match)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = RAW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = RAW'(a);
        #1 d = bus_rdata;
    endtask

    // kind: 0 = instruction, 1 = read, 2 = write
    task automatic ev(input int kind, input logic [31:0] a, output logic m);
        @(negedge clk);
        if (kind == 0) begin instr_valid = 1'b1; instr_addr = a; end
        else begin data_valid = 1'b1; data_write = (kind == 2); data_addr = a; end
        @(negedge clk);
        m = wp_match;
        instr_valid = 1'b0; data_valid = 1'b0; data_write = 1'b0;
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic [31:0] d;
        logic m;
        logic [31:0] v;
        v = 32'hA5A5_8000;
        repeat (3) @(negedge clk);
        check("R9 match after reset", {31'd0, wp_match}, 32'd0);
        rst = 1'b0;
        rd('h20, d); check("R9 value0 reset", d, 32'd0);
        rd('h28, d); check("R9 fn0 reset", d, 32'd0);
        rd('h34, d); check("R9 span1 reset", d, 32'd0);

        rd('h000, d); check("R1 ctrl word", d, 32'h2000_0000);

        // R2 sample register
        instr_addr = 32'h0000_4321;
        rd('h1C, d); check("R2 sample disabled", d, 32'hFFFF_FFFF);
        unit_en = 1'b1;
        rd('h1C, d); check("R2 sample running", d, 32'h0000_4321);
        halted = 1'b1;
        rd('h1C, d); check("R2 sample halted", d, 32'hFFFF_FFFF);
        halted = 1'b0;

        // R6 register readback and unmapped
        wr('h30, 32'hDEAD_BEEF);
        rd('h30, d); check("R6 value1 readback", d, 32'hDEAD_BEEF);
        wr('h34, 32'hFFFF_FFF7);
        rd('h34, d); check("R3 span1 zero-extended", d, 32'h0000_0007);
        wr('h38, 32'h0000_000B);
        rd('h38, d); check("R5 reserved fn reads back", d, 32'h0000_000B);
        rd('h2C, d); check("R6 unmapped offset", d, 32'd0);
        wr('h30, 32'd0); wr('h34, 32'd0); wr('h38, 32'd0);

        // R4/R5 function sweep on comparator 0
        wr('h20, v);
        for (int f = 0; f < 16; f++) begin
            wr('h28, 32'(f));
            for (int k = 0; k < 3; k++) begin
                logic e;
                e = (k == 0) ? (f == 4) : (k == 1) ? (f == 5 || f == 7) : (f == 6 || f == 7);
                ev(k, v, m);
                if (f == 4 || (f >= 5 && f <= 7) || f == 0)
                    check($sformatf("R4 fn %0d kind %0d", f, k), {31'd0, m}, {31'd0, e});
                else
                    check($sformatf("R5 fn %0d kind %0d", f, k), {31'd0, m}, {31'd0, e});
            end
        end

        // R3 span sweep, read watch
        wr('h28, 32'h5);
        for (int k = 0; k < 16; k++) begin
            logic [31:0] ain, aout;
            wr('h24, 32'(k));
            ain  = v | ((32'd1 << k) - 32'd1);
            aout = v ^ (32'd1 << k);
            ev(1, ain, m);
            check($sformatf("R3 span %0d inside", k), {31'd0, m}, {31'd0, ((ain ^ v) >> k) == 0});
            ev(1, aout, m);
            check($sformatf("R3 span %0d outside", k), {31'd0, m}, {31'd0, ((aout ^ v) >> k) == 0});
            ev(1, v ^ 32'h8000_0000, m);
            check($sformatf("R3 span %0d top bit", k), {31'd0, m}, 32'd0);
        end
        wr('h24, 32'd0);

        // R10 OR of comparators and single-cycle pulse
        wr('h30, 32'h0000_1000); wr('h38, 32'h6);
        ev(2, 32'h0000_1000, m); check("R10 comparator 1 write", {31'd0, m}, 32'd1);
        @(negedge clk); check("R10 pulse ends", {31'd0, wp_match}, 32'd0);
        ev(1, v, m); check("R10 comparator 0 read", {31'd0, m}, 32'd1);
        ev(1, 32'h0000_1000, m); check("R10 neither", {31'd0, m}, 32'd0);

        // R8 suppression
        unit_en = 1'b0;
        ev(1, v, m); check("R8 disabled read", {31'd0, m}, 32'd0);
        ev(2, 32'h0000_1000, m); check("R8 disabled write", {31'd0, m}, 32'd0);

        // R7 writes dropped while disabled
        wr('h20, 32'h1111_1111);
        wr('h28, 32'h0);
        unit_en = 1'b1;
        rd('h20, d); check("R7 value0 kept", d, v);
        rd('h28, d); check("R7 fn0 kept", d, 32'h5);
        ev(1, v, m); check("R7 comparator still live", {31'd0, m}, 32'd1);

        // R9 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd('h20, d); check("R9 value0 cleared", d, 32'd0);
        rd('h38, d); check("R9 fn1 cleared", d, 32'd0);

        finished = 1;
        finish_up();
    end
endmodule